// File: doc/BRIEF.md
# Learning MAC Address Table

This block holds the forwarding knowledge of a small switch. It learns the source address of each frame, together with the port and device the frame came in on. It answers destination-address queries with the port and device to forward to. Storage is an array of buckets with four entries each. A bucket is chosen by folding the 48-bit address down to an index. A request is taken through a short fixed sequence: read the bucket, compare all entries in parallel, then respond and, for a learn, write one entry.

Port values 0 and 1 name the two local Ethernet ports, and 2 names the expansion port. Each entry also carries a 4-bit stamp taken from a write counter. When every entry of a bucket is valid, the stamp decides which entry a new address evicts. After reset the block sweeps the whole array to invalidate it, and it refuses requests until the sweep is over. A lookup that misses asks the caller to flood the frame.

Top module: `mac_learn_table`

## Requirements
- R1: While `rst` is high, and for the first 2^IDX_W clock cycles after it falls, `busy_init` is 1 and `req_ready` is 0. After that sweep every entry is invalid, so any lookup misses.
- R2: `req_ready` is 1 only when the block is idle and not sweeping. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the cycle after that edge, `req_ready` is 0.
- R3: `rsp_valid` is 1 for exactly one cycle: the cycle that follows the first rising edge after the accepting edge.
- R4: A lookup (`req_learn`=0) whose address is stored returns `rsp_hit`=1, `rsp_flood`=0, and the stored port and device.
- R5: A lookup that misses returns `rsp_hit`=0, `rsp_flood`=1, and port and device equal to 0. It leaves the table unchanged.
- R6: The bucket index has bit j equal to the XOR of every address bit i with i mod IDX_W = j. A learned unicast address that is not yet present goes into the lowest-numbered invalid entry of its bucket.
- R7: A learn whose address has bit 40 (the group bit) set never writes the table.
- R8: A learn of an address already stored with a different port or device rewrites that same entry with the new values and a fresh stamp. A learn with identical port and device writes nothing.
- R9: When a new unicast address finds all four entries of its bucket valid, it replaces the entry with the largest (counter − stamp) mod 16. On a tie, the lowest-numbered entry is replaced.
- R10: A 4-bit write counter starts at 0. Every table write stores the counter's current value as the entry's stamp, then increments the counter modulo 16. Nothing else changes the counter.
- R11: A learn response gives `rsp_flood`=0. It sets `rsp_hit` to whether the address was stored before the request. On a hit it reports the port and device held before any rewrite; otherwise it reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_learn | input | 1 | 1 = learn source address, 0 = look up destination |
| req_mac | input | 48 | Address to learn or look up |
| req_port | input | 2 | Ingress port for a learn (0, 1 local, 2 expansion) |
| req_dev | input | 4 | Ingress device number for a learn |
| busy_init | output | 1 | Invalidation sweep in progress |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Address was found |
| rsp_flood | output | 1 | Lookup miss, frame must be flooded |
| rsp_port | output | 2 | Port of the matched entry |
| rsp_dev | output | 4 | Device of the matched entry |

## Verification
A request is sampled on the rising edge where it is accepted. One rising edge later the bucket has been read and `req_ready` has dropped. At the next rising edge the response fields are registered and any learn write lands in the array, so a request accepted in the response cycle already sees the updated table. The bench drives inputs on falling edges. It checks `req_ready` and the absence of `rsp_valid` one falling edge after acceptance, and checks the response fields one falling edge later. The end of the sweep is checked at falling edges 2^IDX_W − 1 and 2^IDX_W after reset release. A reference model of the table and write counter supplies every expected hit, port, device and eviction.

// File: rtl/mac_tbl_pkg.sv
package mac_tbl_pkg;

    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;
    localparam int PORT_W    = 2;
    localparam int DEV_W     = 4;
    localparam int STAMP_W   = 4;
    localparam int FOLD_W    = 16;

    typedef logic [MAC_W-1:0]   mac_t;
    typedef logic [PORT_W-1:0]  port_t;
    typedef logic [DEV_W-1:0]   dev_t;
    typedef logic [STAMP_W-1:0] stamp_t;

    typedef enum logic {
        OP_LOOKUP = 1'b0,
        OP_LEARN  = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_IDLE,
        ST_EVAL
    } state_e;

    typedef struct packed {
        logic   valid;
        mac_t   mac;
        port_t  port;
        dev_t   dev;
        stamp_t stamp;
    } entry_t;

    typedef struct packed {
        op_e   op;
        mac_t  mac;
        port_t port;
        dev_t  dev;
    } req_t;

    typedef struct packed {
        logic  hit;
        logic  flood;
        port_t port;
        dev_t  dev;
    } rsp_t;

    // Fold the address: bit i lands on index bit (i mod width).
    function automatic logic [FOLD_W-1:0] fold_mac(input mac_t mac, input int width);
        logic [FOLD_W-1:0] h;
        h = '0;
        for (int i = 0; i < MAC_W; i++) begin
            h[4'(i % width)] = h[4'(i % width)] ^ mac[i];
        end
        return h;
    endfunction

    // Modular distance of a stamp from the running write counter.
    function automatic stamp_t stamp_age(input stamp_t now, input stamp_t s);
        return now - s;
    endfunction

    function automatic logic is_group(input mac_t mac);
        return mac[GROUP_BIT];
    endfunction

endpackage

// File: rtl/mac_tbl_store.sv
module mac_tbl_store
    import mac_tbl_pkg::*;
#(
    parameter  int IDX_W   = 4,
    parameter  int WAYS    = 4,
    localparam int BUCKETS = 1 << IDX_W,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic                   clk,
    input  logic                   rd_en,
    input  logic [IDX_W-1:0]       rd_idx,
    output entry_t [WAYS-1:0]      rd_bucket,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [WAY_W-1:0]       wr_way,
    input  entry_t                 wr_entry,
    input  logic                   clr_en,
    input  logic [IDX_W-1:0]       clr_idx
);

    // One bank per way; a bucket is the same row across all banks.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        entry_t bank [BUCKETS];
        entry_t rd_q;

        always_ff @(posedge clk) begin
            if (clr_en) begin
                bank[clr_idx].valid <= 1'b0;
            end else if (wr_en && wr_way == WAY_W'(g)) begin
                bank[wr_idx] <= wr_entry;
            end
            if (rd_en) begin
                rd_q <= bank[rd_idx];
            end
        end

        assign rd_bucket[g] = rd_q;
    end

endmodule

// File: rtl/mac_tbl_match.sv
module mac_tbl_match
    import mac_tbl_pkg::*;
#(
    parameter  int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  entry_t [WAYS-1:0] bucket,
    input  mac_t              mac,
    input  stamp_t            now,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output port_t             hit_port,
    output dev_t              hit_dev,
    output logic              has_free,
    output logic [WAY_W-1:0]  free_way,
    output logic [WAY_W-1:0]  old_way
);

    stamp_t best_age;
    logic   found_old;

    always_comb begin
        hit       = 1'b0;
        hit_way   = '0;
        hit_port  = '0;
        hit_dev   = '0;
        has_free  = 1'b0;
        free_way  = '0;
        old_way   = '0;
        best_age  = '0;
        found_old = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            // Lowest-numbered matching entry wins.
            if (bucket[w].valid && bucket[w].mac == mac && !hit) begin
                hit      = 1'b1;
                hit_way  = WAY_W'(w);
                hit_port = bucket[w].port;
                hit_dev  = bucket[w].dev;
            end
            if (!bucket[w].valid && !has_free) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
            // Strict compare keeps the lowest index on equal age.
            if (!found_old || stamp_age(now, bucket[w].stamp) > best_age) begin
                found_old = 1'b1;
                best_age  = stamp_age(now, bucket[w].stamp);
                old_way   = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/mac_tbl_ctrl.sv
module mac_tbl_ctrl
    import mac_tbl_pkg::*;
#(
    parameter  int IDX_W   = 4,
    parameter  int WAYS    = 4,
    localparam int BUCKETS = 1 << IDX_W,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  req_t               req_in,
    output logic               req_ready,
    output logic               busy_init,
    output logic               rd_en,
    output logic [IDX_W-1:0]   rd_idx,
    input  logic               hit,
    input  logic [WAY_W-1:0]   hit_way,
    input  port_t              hit_port,
    input  dev_t               hit_dev,
    input  logic               has_free,
    input  logic [WAY_W-1:0]   free_way,
    input  logic [WAY_W-1:0]   old_way,
    output mac_t               cmp_mac,
    output stamp_t             stamp_now,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [WAY_W-1:0]   wr_way,
    output entry_t             wr_entry,
    output logic               clr_en,
    output logic [IDX_W-1:0]   clr_idx,
    output logic               rsp_valid,
    output rsp_t               rsp
);

    localparam logic [IDX_W-1:0] LAST_BUCKET = IDX_W'(BUCKETS - 1);

    state_e            state;
    logic [IDX_W-1:0]  sweep;
    req_t              req_q;
    logic [IDX_W-1:0]  idx_q;
    stamp_t            stamp_ctr;
    logic              learn_ok;
    logic              changed;
    rsp_t              rsp_next;

    // Request side
    assign req_ready = (state == ST_IDLE);
    assign busy_init = (state == ST_INIT);
    assign rd_en     = req_ready && req_valid;
    assign rd_idx    = IDX_W'(fold_mac(req_in.mac, IDX_W));

    // Sweep side
    assign clr_en  = busy_init;
    assign clr_idx = sweep;

    // Compare side
    assign cmp_mac   = req_q.mac;
    assign stamp_now = stamp_ctr;

    // Write decision
    assign learn_ok = (state == ST_EVAL) && (req_q.op == OP_LEARN) && !is_group(req_q.mac);
    assign changed  = (hit_port != req_q.port) || (hit_dev != req_q.dev);

    always_comb begin
        wr_en          = learn_ok && (!hit || changed);
        wr_idx         = idx_q;
        wr_way         = hit ? hit_way : (has_free ? free_way : old_way);
        wr_entry.valid = 1'b1;
        wr_entry.mac   = req_q.mac;
        wr_entry.port  = req_q.port;
        wr_entry.dev   = req_q.dev;
        wr_entry.stamp = stamp_ctr;
    end

    always_comb begin
        rsp_next.hit   = hit;
        rsp_next.flood = (req_q.op == OP_LOOKUP) && !hit;
        rsp_next.port  = hit ? hit_port : '0;
        rsp_next.dev   = hit ? hit_dev  : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_INIT;
            sweep     <= '0;
            req_q     <= '0;
            idx_q     <= '0;
            stamp_ctr <= '0;
            rsp_valid <= 1'b0;
            rsp       <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_INIT: begin
                    if (sweep == LAST_BUCKET) begin
                        state <= ST_IDLE;
                    end else begin
                        sweep <= sweep + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        idx_q <= rd_idx;
                        state <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    rsp_valid <= 1'b1;
                    rsp       <= rsp_next;
                    if (wr_en) begin
                        stamp_ctr <= stamp_ctr + 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_INIT;
            endcase
        end
    end

endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table
    import mac_tbl_pkg::*;
#(
    parameter  int IDX_W = 4,
    parameter  int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_learn,
    input  logic [47:0] req_mac,
    input  logic [1:0]  req_port,
    input  logic [3:0]  req_dev,
    output logic        busy_init,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_flood,
    output logic [1:0]  rsp_port,
    output logic [3:0]  rsp_dev
);

    req_t              req_in;
    rsp_t              rsp;
    entry_t [WAYS-1:0] bucket;
    logic              rd_en;
    logic [IDX_W-1:0]  rd_idx;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WAY_W-1:0]  wr_way;
    entry_t            wr_entry;
    logic              clr_en;
    logic [IDX_W-1:0]  clr_idx;
    mac_t              cmp_mac;
    stamp_t            stamp_now;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    port_t             hit_port;
    dev_t              hit_dev;
    logic              has_free;
    logic [WAY_W-1:0]  free_way;
    logic [WAY_W-1:0]  old_way;

    always_comb begin
        req_in.op   = req_learn ? OP_LEARN : OP_LOOKUP;
        req_in.mac  = req_mac;
        req_in.port = req_port;
        req_in.dev  = req_dev;
    end

    mac_tbl_store #(.IDX_W(IDX_W), .WAYS(WAYS)) u_store (
        .clk       (clk),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_bucket (bucket),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_way    (wr_way),
        .wr_entry  (wr_entry),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx)
    );

    mac_tbl_match #(.WAYS(WAYS)) u_match (
        .bucket   (bucket),
        .mac      (cmp_mac),
        .now      (stamp_now),
        .hit      (hit),
        .hit_way  (hit_way),
        .hit_port (hit_port),
        .hit_dev  (hit_dev),
        .has_free (has_free),
        .free_way (free_way),
        .old_way  (old_way)
    );

    mac_tbl_ctrl #(.IDX_W(IDX_W), .WAYS(WAYS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .busy_init (busy_init),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .hit       (hit),
        .hit_way   (hit_way),
        .hit_port  (hit_port),
        .hit_dev   (hit_dev),
        .has_free  (has_free),
        .free_way  (free_way),
        .old_way   (old_way),
        .cmp_mac   (cmp_mac),
        .stamp_now (stamp_now),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_way    (wr_way),
        .wr_entry  (wr_entry),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .rsp_valid (rsp_valid),
        .rsp       (rsp)
    );

    assign rsp_hit   = rsp.hit;
    assign rsp_flood = rsp.flood;
    assign rsp_port  = rsp.port;
    assign rsp_dev   = rsp.dev;

endmodule

// File: rtl/mac_tbl_chk.sv
module mac_tbl_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic busy_init,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_flood
);

    logic accept;
    assign accept = req_valid && req_ready;

    AST_SWEEP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
        busy_init |-> !req_ready); // R1
    AST_SWEEP_RUNS_ONCE: assert property (@(posedge clk) disable iff (rst)
        !busy_init |=> !busy_init); // R1
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready); // R2
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 rsp_valid); // R3
    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(accept, 2)); // R3
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R3
    AST_FLOOD_ONLY_MISS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_flood) |-> !rsp_hit); // R5

endmodule

bind mac_learn_table mac_tbl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy_init (busy_init),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_flood (rsp_flood)
);

// File: tb/tb_mac_learn_table.sv
module tb_mac_learn_table;

    localparam int IDX_W   = 4;
    localparam int WAYS    = 4;
    localparam int BUCKETS = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic        req_learn;
    logic [47:0] req_mac;
    logic [1:0]  req_port;
    logic [3:0]  req_dev;
    logic        busy_init;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_flood;
    logic [1:0]  rsp_port;
    logic [3:0]  rsp_dev;

    int n_checks = 0;
    int n_err    = 0;

    // Reference model of the table
    bit          m_valid [BUCKETS][WAYS];
    logic [47:0] m_mac   [BUCKETS][WAYS];
    logic [1:0]  m_port  [BUCKETS][WAYS];
    logic [3:0]  m_dev   [BUCKETS][WAYS];
    int          m_stamp [BUCKETS][WAYS];
    int          m_ctr = 0;

    logic [47:0] pool [40];
    logic [47:0] ev   [7];

    always #2.5 clk = ~clk;

    mac_learn_table #(.IDX_W(IDX_W), .WAYS(WAYS)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_learn(req_learn), .req_mac(req_mac), .req_port(req_port), .req_dev(req_dev),
        .busy_init(busy_init), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_flood(rsp_flood), .rsp_port(rsp_port), .rsp_dev(rsp_dev)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R6: index bit j is the XOR of all address bits i with i mod IDX_W == j
    function automatic int bhash(input logic [47:0] mac);
        logic [IDX_W-1:0] h;
        h = '0;
        for (int i = 0; i < 48; i++) h[i % IDX_W] ^= mac[i];
        return int'(h);
    endfunction

    // Unicast address forced into a chosen bucket
    function automatic logic [47:0] mk_mac(input int bucket, input bit group);
        logic [47:0] m;
        int h;
        m = {$urandom(), $urandom()};
        m[40] = group;
        h = bhash(m);
        m[IDX_W-1:0] = m[IDX_W-1:0] ^ IDX_W'(h) ^ IDX_W'(bucket);
        return m;
    endfunction

    task automatic model_write(input int b, input int w, input logic [47:0] mac,
                               input logic [1:0] port, input logic [3:0] dev);
        m_valid[b][w] = 1'b1;
        m_mac[b][w]   = mac;
        m_port[b][w]  = port;
        m_dev[b][w]   = dev;
        m_stamp[b][w] = m_ctr;          // R10
        m_ctr         = (m_ctr + 1) % 16;
    endtask

    // One request, driven from a falling edge, returning at a falling edge.
    task automatic do_op(input bit learn, input logic [47:0] mac,
                         input logic [1:0] port, input logic [3:0] dev);
        int b, hw, fw, ow, best, age;
        bit e_hit, e_flood;
        logic [1:0] e_port;
        logic [3:0] e_dev;
        b = bhash(mac);
        hw = -1; fw = -1; ow = 0; best = -1;
        for (int w = 0; w < WAYS; w++) begin
            if (hw < 0 && m_valid[b][w] && m_mac[b][w] == mac) hw = w;
            if (fw < 0 && !m_valid[b][w]) fw = w;
            age = (m_ctr - m_stamp[b][w] + 16) % 16;
            if (age > best) begin best = age; ow = w; end   // R9 lowest on tie
        end
        e_hit   = (hw >= 0);
        e_flood = !learn && !e_hit;
        e_port  = e_hit ? m_port[b][hw] : 2'd0;
        e_dev   = e_hit ? m_dev[b][hw]  : 4'd0;

        req_valid = 1'b1;
        req_learn = learn;
        req_mac   = mac;
        req_port  = port;
        req_dev   = dev;
        check(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
        check(rsp_valid == 1'b0, "R3 no early response", rsp_valid, 0);
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R3 response due", rsp_valid, 1);
        check(rsp_hit == e_hit, learn ? "R11 learn hit" : "R4 lookup hit", rsp_hit, e_hit);
        check(rsp_flood == e_flood, learn ? "R11 learn flood" : "R5 lookup flood", rsp_flood, e_flood);
        check(rsp_port == e_port, learn ? "R11 prior port" : "R4 port", rsp_port, e_port);
        check(rsp_dev == e_dev, learn ? "R11 prior dev" : "R4 dev", rsp_dev, e_dev);

        if (learn && !mac[40]) begin                      // R7
            if (e_hit) begin
                if (m_port[b][hw] != port || m_dev[b][hw] != dev)
                    model_write(b, hw, mac, port, dev);   // R8
            end else begin
                model_write(b, (fw >= 0) ? fw : ow, mac, port, dev); // R6 R9
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [47:0] gm;
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < BUCKETS; b++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[b][w] = 1'b0;
                m_stamp[b][w] = 0;
            end
        rst = 1'b1; req_valid = 1'b0; req_learn = 1'b0;
        req_mac = '0; req_port = '0; req_dev = '0;
        repeat (3) @(negedge clk);
        check(busy_init == 1'b1, "R1 busy in reset", busy_init, 1);
        check(req_ready == 1'b0, "R1 not ready in reset", req_ready, 0);
        check(rsp_valid == 1'b0, "R3 no response in reset", rsp_valid, 0);
        rst = 1'b0;
        for (int k = 1; k <= BUCKETS; k++) begin
            @(negedge clk);
            if (k == BUCKETS - 1) begin
                check(busy_init == 1'b1, "R1 sweep still running", busy_init, 1);
                check(req_ready == 1'b0, "R1 blocked during sweep", req_ready, 0);
            end
        end
        check(busy_init == 1'b0, "R1 sweep done", busy_init, 0);
        check(req_ready == 1'b1, "R1 ready after sweep", req_ready, 1);

        // R1 R5: empty table misses everywhere
        for (int i = 0; i < 6; i++) do_op(1'b0, mk_mac(i * 3, 1'b0), 2'd0, 4'd0);

        // R4 R6 R11: learn then look up
        ev[0] = mk_mac(5, 1'b0);
        do_op(1'b1, ev[0], 2'd1, 4'd3);
        do_op(1'b0, ev[0], 2'd0, 4'd0);
        // R7: group address not learned
        gm = mk_mac(5, 1'b1);
        do_op(1'b1, gm, 2'd2, 4'd7);
        do_op(1'b0, gm, 2'd0, 4'd0);
        // R8 R11: changed port/device rewrites in place
        do_op(1'b1, ev[0], 2'd2, 4'd5);
        do_op(1'b0, ev[0], 2'd0, 4'd0);

        // R9 R10 R8: fill bucket 0, refresh one, evict oldest twice
        for (int i = 0; i < 7; i++) ev[i] = mk_mac(0, 1'b0);
        for (int i = 0; i < 4; i++) do_op(1'b1, ev[i], 2'(i % 3), 4'(i));
        do_op(1'b1, ev[1], 2'd2, 4'd9);        // R8 refresh ev1
        do_op(1'b1, ev[4], 2'd0, 4'd4);        // R9 evicts ev0
        do_op(1'b0, ev[0], 2'd0, 4'd0);
        do_op(1'b0, ev[1], 2'd0, 4'd0);
        do_op(1'b1, ev[5], 2'd1, 4'd6);        // R9 evicts ev2
        do_op(1'b0, ev[2], 2'd0, 4'd0);
        do_op(1'b1, ev[3], 2'd0, 4'd3);        // R8 identical, no write
        do_op(1'b1, ev[6], 2'd1, 4'd1);        // R10 evicts ev3
        do_op(1'b0, ev[3], 2'd0, 4'd0);
        do_op(1'b0, ev[1], 2'd0, 4'd0);

        // Random mix over four crowded buckets
        for (int i = 0; i < 40; i++) pool[i] = mk_mac(int'($urandom() % 4), ($urandom() % 8) == 0);
        for (int n = 0; n < 3000; n++) begin
            do_op(1'($urandom() % 2), pool[$urandom() % 40],
                  2'($urandom() % 3), 4'($urandom() % 2));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule